// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address. It does this by reading two page table entries through a simple memory read port. The logical address has three parts. The top 12 bits select an entry in the outer table, the next 10 bits select an entry in an inner table, and the low 10 bits are the byte offset inside a 1 KB page. The outer table starts at an address held in a base input. A length input sets how many outer entries are legal.

A request carries the logical address and two access flags: write and instruction fetch. The walker works through the following steps in order:
- It checks the outer index against the length.
- It reads the outer entry and checks it.
- It reads the inner entry and checks it.
- It joins the frame number from the inner entry with the offset.

The walk ends in one of two ways. Either a one-cycle done pulse comes with the physical address, or a one-cycle fault pulse comes with a code that names the cause. Only one walk is in flight at a time, and `busy` covers the whole walk. With no translation cache, every translation costs two table reads before the data access can start.

Top module: `pt_walker`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `fault` and `mem_rd_req` are all low.
- R2: A request is taken when `req_valid` is high and `busy` is low. `busy` is high from the next cycle until the cycle after the done or fault pulse. A request presented while `busy` is high is ignored: it does not change the result and it starts no walk.
- R3: The outer index is `req_vaddr[31:20]`. If it is greater than or equal to `pt_len`, the walk ends one cycle after acceptance with `fault` and `fault_code` = 1. No memory read is issued in that case.
- R4: The first read is at `(pt_base with bits [1:0] cleared) + 4*outer`. The second read is at `{outer_entry[31:10], 10'b0} + 4*req_vaddr[19:10]`. `mem_rd_addr` holds steady while `mem_rd_req` is high and `mem_rd_ack` is low.
- R5: Entry layout: bit 0 is valid, bit 1 is writable, bit 2 is executable, and bits [31:10] are the frame or the next-table base. Bits [9:3] are ignored. An entry with bit 0 clear ends the walk with `fault_code` = 2, and no further read follows.
- R6: A write request needs bit 1 set, and a fetch request needs bit 2 set, in both the outer and the inner entry. Otherwise the walk ends with `fault_code` = 3. A plain read needs neither bit. In the same entry, the valid check comes before the permission check.
- R7: On success, `done` pulses and `paddr` = `{inner_entry[31:10], req_vaddr[9:0]}`. The walk takes exactly two memory reads.
- R8: `done` and `fault` are single-cycle pulses that never occur together. `fault_code` is non-zero whenever `fault` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Logical address |
| req_write | input | 1 | Access is a write |
| req_fetch | input | 1 | Access is an instruction fetch |
| pt_base | input | 32 | Outer table base address |
| pt_len | input | 13 | Number of legal outer entries |
| busy | output | 1 | Walk in progress |
| mem_rd_req | output | 1 | Table read request |
| mem_rd_addr | output | 32 | Table read byte address |
| mem_rd_ack | input | 1 | Read data valid this cycle |
| mem_rd_data | input | 32 | Table entry read |
| done | output | 1 | Translation complete pulse |
| paddr | output | 32 | Physical address, valid with done |
| fault | output | 1 | Translation failed pulse |
| fault_code | output | 2 | 1 bound, 2 invalid entry, 3 permission |

## Verification
A wrong walk state shows at the ports within one table read. It appears as a read at the wrong address, as a missing or extra read, or as a done or fault pulse that comes early, comes twice or never comes. The bench sweeps outer and inner indices across the length boundary and all four combinations of the access flags. Each sweep uses table contents built from simple arithmetic patterns, so every step of the walk has an expected address, read count, fault code and physical address that the bench can compute. Response latency is varied so that a state that does not wait for the acknowledge is exposed.

// File: rtl/pt_walker_pkg.sv
// Package: shared types and entry-bit positions for the table walker.
// Assumes one entry format for both table levels.
package pt_walker_pkg;

    // Result code reported with a fault pulse
    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_BOUND   = 2'd1,
        FLT_INVALID = 2'd2,
        FLT_PERM    = 2'd3
    } fault_e;

    // Walk sequencing states
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_READ_L1 = 3'd1,
        ST_READ_L2 = 3'd2,
        ST_DONE    = 3'd3,
        ST_FAULT   = 3'd4
    } walk_state_e;

    // Bit positions of the flag fields inside an entry
    localparam int PTE_VALID_BIT = 0;
    localparam int PTE_WRITE_BIT = 1;
    localparam int PTE_EXEC_BIT  = 2;

endpackage

// File: rtl/pt_addr_gen.sv
// Address generator: splits the logical address into its indices, checks
// the outer index against the length, and forms both table read addresses.
// Assumes table entries are 4 bytes wide and the next-level base is page aligned.
module pt_addr_gen #(
    parameter int VA_W  = 32,
    parameter int PA_W  = 32,
    parameter int PTE_W = 32,
    parameter int L1_W  = 12,
    parameter int L2_W  = 10,
    parameter int LEN_W = L1_W + 1
) (
    input  logic [VA_W-1:0]  vaddr,
    input  logic [PA_W-1:0]  base,
    input  logic [LEN_W-1:0] len,
    input  logic [PTE_W-1:0] l1_pte,
    input  logic [L2_W-1:0]  l2_idx_q,
    output logic [L2_W-1:0]  l2_idx,
    output logic [VA_W-L1_W-L2_W-1:0] offset,
    output logic             out_of_bound,
    output logic [PA_W-1:0]  l1_addr,
    output logic [PA_W-1:0]  l2_addr
);
    localparam int OFF_W = VA_W - L1_W - L2_W;
    localparam int FRM_W = PA_W - OFF_W;

    logic [L1_W-1:0] l1_idx;
    logic [PA_W-1:0] base_aligned;
    logic [PA_W-1:0] next_base;

    // Field extraction from the logical address
    always_comb begin
        l1_idx = vaddr[VA_W-1 -: L1_W];
        l2_idx = vaddr[OFF_W +: L2_W];
        offset = vaddr[OFF_W-1:0];
    end

    // Outer index bound check against the length register
    always_comb begin
        out_of_bound = ({1'b0, l1_idx} >= {{(L1_W+1-LEN_W){1'b0}}, len});
    end

    // Read address of the outer entry, base forced to word alignment
    always_comb begin
        base_aligned = base & ~{{(PA_W-2){1'b0}}, 2'b11};
        l1_addr      = base_aligned + (PA_W'(l1_idx) << 2);
    end

    // Read address of the inner entry from the fetched outer entry
    always_comb begin
        next_base = {l1_pte[PTE_W-1 -: FRM_W], {OFF_W{1'b0}}};
        l2_addr   = next_base + (PA_W'(l2_idx_q) << 2);
    end

    logic unused_pte_low;
    assign unused_pte_low = ^l1_pte[PTE_W-FRM_W-1:0];
endmodule

// File: rtl/pt_entry_check.sv
// Entry checker: decides whether one fetched entry lets the access go on.
// Assumes the valid check ranks above the permission check.
module pt_entry_check
    import pt_walker_pkg::*;
#(
    parameter int PTE_W = 32
) (
    input  logic [PTE_W-1:0] pte,
    input  logic             want_write,
    input  logic             want_exec,
    output logic             pass,
    output fault_e           code
);
    logic is_valid;
    logic perm_ok;

    // Decode flags and evaluate permissions for the access kind
    always_comb begin
        is_valid = pte[PTE_VALID_BIT];
        perm_ok  = (!want_write || pte[PTE_WRITE_BIT]) &&
                   (!want_exec  || pte[PTE_EXEC_BIT]);
    end

    // Rank the violations: invalid first, then permission
    always_comb begin
        if (!is_valid) begin
            pass = 1'b0;
            code = FLT_INVALID;
        end else if (!perm_ok) begin
            pass = 1'b0;
            code = FLT_PERM;
        end else begin
            pass = 1'b1;
            code = FLT_NONE;
        end
    end

    logic unused_pte_bits;
    assign unused_pte_bits = ^{pte[PTE_W-1:PTE_EXEC_BIT+1]};
endmodule

// File: rtl/pt_walk_fsm.sv
// Walk sequencer: accepts one request, issues the two table reads in order,
// and ends with a one-cycle done or fault pulse.
// Assumes read data is valid in the cycle mem_ack is high.
module pt_walk_fsm
    import pt_walker_pkg::*;
#(
    parameter int PA_W  = 32,
    parameter int PTE_W = 32,
    parameter int L2_W  = 10,
    parameter int OFF_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_fetch,
    input  logic [L2_W-1:0]  l2_idx_in,
    input  logic [OFF_W-1:0] offset_in,
    input  logic             out_of_bound,
    input  logic [PA_W-1:0]  l1_addr,
    input  logic [PA_W-1:0]  l2_addr,
    input  logic             mem_ack,
    input  logic [PTE_W-1:0] mem_data,
    input  logic             chk_pass,
    input  fault_e           chk_code,
    output logic             want_write,
    output logic             want_exec,
    output logic [L2_W-1:0]  l2_idx_q,
    output logic             busy,
    output logic             rd_req,
    output logic [PA_W-1:0]  rd_addr,
    output logic             done,
    output logic [PA_W-1:0]  paddr,
    output logic             fault,
    output fault_e           fault_code
);
    localparam int FRM_W = PA_W - OFF_W;

    walk_state_e state;
    logic [OFF_W-1:0] offset_q;

    // Sequencing and capture of request fields, read address and result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            want_write <= 1'b0;
            want_exec  <= 1'b0;
            l2_idx_q   <= '0;
            offset_q   <= '0;
            rd_addr    <= '0;
            paddr      <= '0;
            fault_code <= FLT_NONE;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        want_write <= req_write;
                        want_exec  <= req_fetch;
                        l2_idx_q   <= l2_idx_in;
                        offset_q   <= offset_in;
                        if (out_of_bound) begin
                            fault_code <= FLT_BOUND;
                            state      <= ST_FAULT;
                        end else begin
                            rd_addr <= l1_addr;
                            state   <= ST_READ_L1;
                        end
                    end
                end
                ST_READ_L1: begin
                    if (mem_ack) begin
                        if (!chk_pass) begin
                            fault_code <= chk_code;
                            state      <= ST_FAULT;
                        end else begin
                            rd_addr <= l2_addr;
                            state   <= ST_READ_L2;
                        end
                    end
                end
                ST_READ_L2: begin
                    if (mem_ack) begin
                        if (!chk_pass) begin
                            fault_code <= chk_code;
                            state      <= ST_FAULT;
                        end else begin
                            paddr <= {mem_data[PTE_W-1 -: FRM_W], offset_q};
                            state <= ST_DONE;
                        end
                    end
                end
                ST_DONE:  state <= ST_IDLE;
                ST_FAULT: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Status and handshake outputs decoded from the state
    always_comb begin
        busy   = (state != ST_IDLE);
        rd_req = (state == ST_READ_L1) || (state == ST_READ_L2);
        done   = (state == ST_DONE);
        fault  = (state == ST_FAULT);
    end
endmodule

// File: rtl/pt_walker.sv
// Top of the two-level table walker: ties the address generator, the
// entry checker and the sequencer together.
// Assumes one outstanding table read at a time.
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int PA_W  = 32,
    parameter int PTE_W = 32,
    parameter int L1_W  = 12,
    parameter int L2_W  = 10,
    parameter int LEN_W = L1_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    input  logic             req_fetch,
    input  logic [PA_W-1:0]  pt_base,
    input  logic [LEN_W-1:0] pt_len,
    output logic             busy,
    output logic             mem_rd_req,
    output logic [PA_W-1:0]  mem_rd_addr,
    input  logic             mem_rd_ack,
    input  logic [PTE_W-1:0] mem_rd_data,
    output logic             done,
    output logic [PA_W-1:0]  paddr,
    output logic             fault,
    output logic [1:0]       fault_code
);
    localparam int OFF_W = VA_W - L1_W - L2_W;

    logic [L2_W-1:0]  l2_idx;
    logic [L2_W-1:0]  l2_idx_q;
    logic [OFF_W-1:0] offset;
    logic             out_of_bound;
    logic [PA_W-1:0]  l1_addr;
    logic [PA_W-1:0]  l2_addr;
    logic             want_write;
    logic             want_exec;
    logic             chk_pass;
    fault_e           chk_code;
    fault_e           code_q;
    logic             req_take;

    // A request is taken only while no walk is running
    assign req_take   = req_valid && !busy;
    assign fault_code = code_q;

    pt_addr_gen #(
        .VA_W(VA_W), .PA_W(PA_W), .PTE_W(PTE_W),
        .L1_W(L1_W), .L2_W(L2_W), .LEN_W(LEN_W)
    ) u_addr (
        .vaddr        (req_vaddr),
        .base         (pt_base),
        .len          (pt_len),
        .l1_pte       (mem_rd_data),
        .l2_idx_q     (l2_idx_q),
        .l2_idx       (l2_idx),
        .offset       (offset),
        .out_of_bound (out_of_bound),
        .l1_addr      (l1_addr),
        .l2_addr      (l2_addr)
    );

    pt_entry_check #(.PTE_W(PTE_W)) u_check (
        .pte        (mem_rd_data),
        .want_write (want_write),
        .want_exec  (want_exec),
        .pass       (chk_pass),
        .code       (chk_code)
    );

    pt_walk_fsm #(
        .PA_W(PA_W), .PTE_W(PTE_W), .L2_W(L2_W), .OFF_W(OFF_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_take),
        .req_write    (req_write),
        .req_fetch    (req_fetch),
        .l2_idx_in    (l2_idx),
        .offset_in    (offset),
        .out_of_bound (out_of_bound),
        .l1_addr      (l1_addr),
        .l2_addr      (l2_addr),
        .mem_ack      (mem_rd_ack),
        .mem_data     (mem_rd_data),
        .chk_pass     (chk_pass),
        .chk_code     (chk_code),
        .want_write   (want_write),
        .want_exec    (want_exec),
        .l2_idx_q     (l2_idx_q),
        .busy         (busy),
        .rd_req       (mem_rd_req),
        .rd_addr      (mem_rd_addr),
        .done         (done),
        .paddr        (paddr),
        .fault        (fault),
        .fault_code   (code_q)
    );
endmodule

// File: rtl/pt_walker_chk.sv
// Checker: port-level protocol properties of the walker, bound to the top.
module pt_walker_chk #(
    parameter int VA_W  = 32,
    parameter int PA_W  = 32,
    parameter int L1_W  = 12,
    parameter int LEN_W = L1_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [VA_W-1:0]  req_vaddr,
    input logic [LEN_W-1:0] pt_len,
    input logic             busy,
    input logic             mem_rd_req,
    input logic [PA_W-1:0]  mem_rd_addr,
    input logic             mem_rd_ack,
    input logic             done,
    input logic             fault,
    input logic [1:0]       fault_code
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd_req && !done && !fault)); // R1

    AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy); // R2

    AST_BOUND_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && ({1'b0, req_vaddr[VA_W-1 -: L1_W]} >= pt_len))
        |=> (fault && fault_code == 2'd1)); // R3

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr))); // R4

    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> (mem_rd_addr[1:0] == 2'b00)); // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R8

    AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (!fault && !busy)); // R8

    AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault)); // R8

    AST_CODE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (fault_code != 2'd0)); // R8
endmodule

bind pt_walker pt_walker_chk #(
    .VA_W(VA_W), .PA_W(PA_W), .L1_W(L1_W), .LEN_W(LEN_W)
) u_pt_walker_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_vaddr   (req_vaddr),
    .pt_len      (pt_len),
    .busy        (busy),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_ack  (mem_rd_ack),
    .done        (done),
    .fault       (fault),
    .fault_code  (fault_code)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;
    localparam logic [31:0] TBL_BASE = 32'h0001_0000;
    localparam logic [31:0] INNER_AREA = 32'h0010_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_fetch = 1'b0;
    logic [31:0] pt_base = TBL_BASE | 32'h3;
    logic [12:0] pt_len = 13'd4000;
    logic        busy, mem_rd_req, done, fault;
    logic [31:0] mem_rd_addr, paddr;
    logic        mem_rd_ack = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic [1:0]  fault_code;

    int checks = 0;
    int fails = 0;
    int lat = 0;
    int wait_cnt = 0;
    int reads = 0;
    logic [31:0] addr_log [2];

    always #5 clk = ~clk;

    pt_walker i_pt_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_fetch(req_fetch), .pt_base(pt_base),
        .pt_len(pt_len), .busy(busy), .mem_rd_req(mem_rd_req),
        .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
        .mem_rd_data(mem_rd_data), .done(done), .paddr(paddr),
        .fault(fault), .fault_code(fault_code)
    );

    function automatic logic [31:0] outer_pte(int i);
        logic v, w, x;
        v = (i % 5) != 4;
        w = (i % 3) != 0;
        x = (i % 4) != 3;
        return (INNER_AREA + 32'(i) * 32'h1000) | {29'd0, x, w, v};
    endfunction

    function automatic logic [31:0] inner_pte(int i, int j);
        logic v, w, x;
        logic [21:0] frm;
        v = (j % 7) != 6;
        w = (j % 2) == 0;
        x = (j % 3) != 1;
        frm = 22'(i * 1024 + j) ^ 22'h15A5A;
        return {frm, 7'd0, x, w, v};
    endfunction

    function automatic logic [31:0] model(logic [31:0] a);
        if (a >= INNER_AREA)
            return inner_pte(int'((a - INNER_AREA) >> 12), int'((a >> 2) & 32'h3FF));
        return outer_pte(int'((a - TBL_BASE) >> 2));
    endfunction

    // Memory responder: answers after lat idle cycles, one cycle of ack per read
    always @(negedge clk) begin
        if (mem_rd_ack) begin
            mem_rd_ack = 1'b0;
            wait_cnt = 0;
        end else if (mem_rd_req) begin
            if (wait_cnt >= lat) begin
                mem_rd_data = model(mem_rd_addr);
                if (reads < 2) addr_log[reads] = mem_rd_addr;
                reads = reads + 1;
                mem_rd_ack = 1'b1;
            end else begin
                wait_cnt = wait_cnt + 1;
            end
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Run one walk and compare against arithmetically computed results
    task automatic walk(int i, int j, int off, bit w, bit x, bit poke);
        int exp_code, exp_reads, n;
        logic [31:0] op, ip, exp_pa;
        bit got_done, got_fault;
        exp_code = 0; exp_reads = 2; exp_pa = 0;
        op = outer_pte(i);
        ip = inner_pte(i, j);
        if (i >= int'(pt_len)) begin exp_code = 1; exp_reads = 0; end
        else if (!op[0]) begin exp_code = 2; exp_reads = 1; end
        else if ((w && !op[1]) || (x && !op[2])) begin exp_code = 3; exp_reads = 1; end
        else if (!ip[0]) exp_code = 2;
        else if ((w && !ip[1]) || (x && !ip[2])) exp_code = 3;
        else exp_pa = {ip[31:10], 10'(off)};
        reads = 0;
        req_vaddr = {12'(i), 10'(j), 10'(off)};
        req_write = w; req_fetch = x; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        got_done = done; got_fault = fault;
        while (!got_done && !got_fault && n < 60) begin
            if (poke) begin
                req_valid = 1'b1;
                req_vaddr = 32'hFFFF_FFFF - 32'(n);
                req_write = ~w; req_fetch = ~x;
            end
            @(negedge clk);
            n++;
            got_done = done; got_fault = fault;
        end
        req_valid = 1'b0;
        if (!got_done && !got_fault) begin
            checks++; fails++;
            $display("FAIL R2: walk %0d/%0d never ended, actual none expected end", i, j);
            return;
        end
        if (exp_code == 0) begin
            check("R7 done", 32'(got_done), 1);
            check("R7 paddr", paddr, exp_pa);
        end else begin
            check(exp_code == 1 ? "R3 fault code" : (exp_code == 2 ? "R5 fault code" : "R6 fault code"),
                  {30'd0, fault_code}, 32'(exp_code));
            check("R8 fault only", 32'(got_done), 0);
        end
        check("R7 read count", 32'(reads), 32'(exp_reads));
        if (exp_reads >= 1) check("R4 outer addr", addr_log[0], TBL_BASE + 32'(i) * 4);
        if (exp_reads == 2) check("R4 inner addr", addr_log[1], INNER_AREA + 32'(i) * 32'h1000 + 32'(j) * 4);
        @(negedge clk);
        check("R8 pulse ends", {30'd0, done, fault}, 0);
        check("R2 idle after", 32'(busy), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int outs [9] = '{0, 1, 2, 3, 4, 5, 11, 3999, 4000};
        int ins [10] = '{0, 1, 2, 3, 4, 5, 6, 13, 1022, 1023};
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset outputs", {28'd0, busy, done, fault, mem_rd_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {28'd0, busy, done, fault, mem_rd_req}, 0);
        // R3 R5 R6 R7: sweep indices, access kinds and latencies
        foreach (outs[a]) begin
            foreach (ins[b]) begin
                for (int k = 0; k < 4; k++) begin
                    lat = (a + b + k) % 3;
                    walk(outs[a], ins[b], (outs[a] * 37 + ins[b] * 11 + k) % 1024, k[0], k[1], 1'b0);
                end
            end
        end
        // R3: length at full table, and length zero
        pt_len = 13'd4096;
        lat = 1;
        walk(4095, 2, 1023, 1'b0, 1'b0, 1'b0);
        walk(4094, 0, 5, 1'b0, 1'b1, 1'b0);
        pt_len = 13'd0;
        walk(0, 0, 0, 1'b0, 1'b0, 1'b0);
        pt_len = 13'd1;
        walk(0, 2, 9, 1'b0, 1'b0, 1'b0);
        walk(1, 2, 9, 1'b0, 1'b0, 1'b0);
        // R2: requests during a walk are ignored
        pt_len = 13'd4000;
        for (int r = 0; r < 3; r++) begin
            lat = r + 1;
            walk(1, 2 * r, 100 + r, 1'b0, 1'b0, 1'b1);
            walk(2, 6, 7, 1'b1, 1'b0, 1'b1);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule